// File: doc/BRIEF.md
# Power Sequencer Restart Controller

This block is the restart supervisor of a multi-rail power manager. It watches the external power-enable and force-shutdown lines, per-rail "below off level" flags, fault triggers, a sequencing-timeout flag, supply-valid flags and the power-off and power-on commands. From these inputs it decides when the rails must come down and how long the power-enable line is held low before the next power-up.

A shutdown caused by a command uses a short hold-off (12.5 ms). A shutdown caused by a fault uses a long one (2.4 s). Both delays are given as cycle counts and are derived from a clock-frequency parameter. Fault-caused restarts are counted against a programmable retry limit. When the count goes over that limit, a lockout is latched. In lockout the block pulls down both shared lines and asserts its reset output until the global reset, which stands for a power cycle.

Top module: `pwr_restart_ctrl`

## Requirements
- R1: After `rst` the state is IDLE, `pwr_en_pull`, `fshut_pull`, `rst_out`, `seq_enable` and `poff_active` are low, and the fault count is zero.
- R2: In SEQ_ON or MONITOR, any of the following moves the block to SHUTDOWN_WAIT_OFF at the next edge with `pwr_en_pull` high: `fault_fs`, `fault_poff`, `seq_timeout` (SEQ_ON only), `fshut_in` high, or `pwr_en_in` low. A fault takes priority over a command and marks the shutdown as fault-caused.
- R3: In SHUTDOWN_WAIT_OFF the block stays put until every bit of `chan_off` is 1, and `pwr_en_pull` stays high the whole time.
- R4: After a command-caused shutdown, the block spends exactly CMD_DLY_CYC cycles in RESTART_DELAY with `pwr_en_pull` high, then enters IDLE with the line released.
- R5: After a fault-caused shutdown, the same holds with FLT_DLY_CYC cycles.
- R6: In LOCKOUT, `pwr_en_pull`, `fshut_pull` and `rst_out` are all high.
- R7: `retry_cfg` 2'b00 allows one fault restart and 2'b01 allows three. Each fault-caused shutdown increments the count, and when all rails are off with the count above the limit the block enters LOCKOUT instead of RESTART_DELAY. With `retry_cfg[1]`=1 it never locks out.
- R8: LOCKOUT ignores every input except `rst`, which clears it.
- R9: From IDLE with `pwr_en_in` high and `fshut_in` low, the block enters WAIT_VALID. It moves to SEQ_ON only once every supply selected in `valid_sel` has its `supply_ok` bit set.
- R10: `seq_enable` is high only in SEQ_ON. In MONITOR, `cmd_off` sets `poff_active` and `cmd_on` clears it. SEQ_ON moves to MONITOR when `chan_off` is all zero.
- R11: A shutdown caused by `fault_fs` drives `fshut_pull` high throughout SHUTDOWN_WAIT_OFF.
- R12: `state_oh` is one-hot. The bits are: bit0 IDLE, bit1 SEQ_ON, bit2 MONITOR, bit3 SHUTDOWN_WAIT_OFF, bit4 RESTART_DELAY, bit5 WAIT_VALID, bit6 LOCKOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pwr_en_in | input | 1 | Level of the shared power-enable line, high = enable |
| fshut_in | input | 1 | Force-shutdown request, high = asserted |
| chan_off | input | N_CH | Per-rail "below off level" flags |
| fault_fs | input | 1 | Fault configured to force a shutdown |
| fault_poff | input | 1 | Fault configured to start a power-off sequence |
| seq_timeout | input | 1 | Sequence-termination timer expired |
| supply_ok | input | N_SUP | Supply within its UV1/OV1 window |
| valid_sel | input | N_SUP | Supplies that must be valid before power-up |
| retry_cfg | input | 2 | Retry limit: 00 one, 01 three, 1x unlimited |
| cmd_off | input | 1 | Power-off command pulse |
| cmd_on | input | 1 | Power-on command pulse |
| pwr_en_pull | output | 1 | Pull power-enable line low |
| fshut_pull | output | 1 | Pull force-shutdown line low |
| rst_out | output | 1 | Reset output, high = asserted |
| seq_enable | output | 1 | Power-on sequencing allowed |
| poff_active | output | 1 | Commanded power-off in progress |
| state_oh | output | 7 | One-hot state |

## Verification
The bench counts the cycles of both hold-off windows exactly. A timer that is off by one, or one that picks the wrong delay for the cause, shows up as RESTART_DELAY one edge too long or too short. It drives faults one past each retry limit. A counter that compares with `>=`, or one that counts command restarts, locks out one restart early or late. It toggles every input during lockout and expects no change, which catches a lockout that is left on a line edge. It holds one rail above its off level and one supply invalid to prove that the delay and the power-up both wait.

// File: rtl/pwr_restart_pkg.sv
package pwr_restart_pkg;
  typedef enum logic [6:0] {
    ST_IDLE    = 7'b0000001,
    ST_SEQ_ON  = 7'b0000010,
    ST_MONITOR = 7'b0000100,
    ST_SHUT    = 7'b0001000,
    ST_DELAY   = 7'b0010000,
    ST_VALID   = 7'b0100000,
    ST_LOCK    = 7'b1000000
  } rs_state_e;

  localparam int B_IDLE  = 0;
  localparam int B_SHUT  = 3;
  localparam int B_DELAY = 4;
  localparam int B_LOCK  = 6;
endpackage

// File: rtl/restart_timer.sv
module restart_timer #(
  parameter int CMD_CYC = 16,
  parameter int FLT_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic sel_fault,
  input  logic run,
  output logic done
);
  localparam int MAXC = (FLT_CYC > CMD_CYC) ? FLT_CYC : CMD_CYC;
  localparam int W    = $clog2(MAXC + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= sel_fault ? W'(FLT_CYC - 1) : W'(CMD_CYC - 1);
    else if (run && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/retry_tracker.sv
module retry_tracker #(
  parameter int CNT_W = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic [1:0] cfg,
  output logic       over
);
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && count != {CNT_W{1'b1}})
      count <= count + 1'b1;
  end

  always_comb begin
    limit = cfg[0] ? CNT_W'(3) : CNT_W'(1);
    over  = !cfg[1] && (count > limit);
  end
endmodule

// File: rtl/pwr_restart_ctrl.sv
module pwr_restart_ctrl
  import pwr_restart_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int N_CH        = 4,
  parameter int N_SUP       = 2,
  parameter int CMD_DLY_CYC = CLK_HZ / 80,
  parameter int FLT_DLY_CYC = (CLK_HZ / 10) * 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_en_in,
  input  logic             fshut_in,
  input  logic [N_CH-1:0]  chan_off,
  input  logic             fault_fs,
  input  logic             fault_poff,
  input  logic             seq_timeout,
  input  logic [N_SUP-1:0] supply_ok,
  input  logic [N_SUP-1:0] valid_sel,
  input  logic [1:0]       retry_cfg,
  input  logic             cmd_off,
  input  logic             cmd_on,
  output logic             pwr_en_pull,
  output logic             fshut_pull,
  output logic             rst_out,
  output logic             seq_enable,
  output logic             poff_active,
  output logic [6:0]       state_oh
);
  rs_state_e state, nxt;
  logic cause_flt, fsk_q, poff_q;
  logic go_flt, go_cmd, load, over, done;
  logic fsk_nxt, poff_nxt, fault_any, cmd_trig, all_off, valid_ok;

  assign all_off   = &chan_off;
  assign valid_ok  = ((supply_ok & valid_sel) == valid_sel);
  assign cmd_trig  = fshut_in | ~pwr_en_in;
  assign fault_any = fault_fs | fault_poff | ((state == ST_SEQ_ON) & seq_timeout);

  restart_timer #(.CMD_CYC(CMD_DLY_CYC), .FLT_CYC(FLT_DLY_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(load), .sel_fault(cause_flt),
    .run(state == ST_DELAY), .done(done)
  );

  retry_tracker #(.CNT_W(3)) u_retry (
    .clk(clk), .rst(rst), .inc(go_flt), .cfg(retry_cfg), .over(over)
  );

  always_comb begin
    nxt    = state;
    go_flt = 1'b0;
    go_cmd = 1'b0;
    load   = 1'b0;
    case (state)
      ST_IDLE:  if (pwr_en_in && !fshut_in) nxt = ST_VALID;
      ST_VALID: begin
        if (!pwr_en_in || fshut_in) nxt = ST_IDLE;
        else if (valid_ok)          nxt = ST_SEQ_ON;
      end
      ST_SEQ_ON, ST_MONITOR: begin
        if (fault_any) begin
          nxt = ST_SHUT; go_flt = 1'b1;
        end else if (cmd_trig) begin
          nxt = ST_SHUT; go_cmd = 1'b1;
        end else if (state == ST_SEQ_ON && !(|chan_off)) begin
          nxt = ST_MONITOR;
        end
      end
      ST_SHUT: begin
        if (all_off) begin
          if (cause_flt && over) nxt = ST_LOCK;
          else begin
            nxt = ST_DELAY; load = 1'b1;
          end
        end
      end
      ST_DELAY: if (done) nxt = ST_IDLE;
      ST_LOCK:  nxt = ST_LOCK;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    fsk_nxt = go_flt ? fault_fs : (go_cmd ? 1'b0 : fsk_q);
    if (nxt != ST_MONITOR || cmd_on) poff_nxt = 1'b0;
    else if (cmd_off)                poff_nxt = 1'b1;
    else                             poff_nxt = poff_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cause_flt   <= 1'b0;
      fsk_q       <= 1'b0;
      poff_q      <= 1'b0;
      pwr_en_pull <= 1'b0;
      fshut_pull  <= 1'b0;
      rst_out     <= 1'b0;
      seq_enable  <= 1'b0;
    end else begin
      state       <= nxt;
      fsk_q       <= fsk_nxt;
      poff_q      <= poff_nxt;
      if (go_flt)      cause_flt <= 1'b1;
      else if (go_cmd) cause_flt <= 1'b0;
      pwr_en_pull <= (nxt == ST_SHUT) || (nxt == ST_DELAY) || (nxt == ST_LOCK);
      fshut_pull  <= (nxt == ST_LOCK) || ((nxt == ST_SHUT) && fsk_nxt);
      rst_out     <= (nxt == ST_LOCK);
      seq_enable  <= (nxt == ST_SEQ_ON);
    end
  end

  assign poff_active = poff_q;
  assign state_oh    = state;
endmodule

// File: rtl/pwr_restart_chk.sv
module pwr_restart_chk
  import pwr_restart_pkg::*;
#(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            pwr_en_in,
  input logic [N_CH-1:0] chan_off,
  input logic [1:0]      retry_cfg,
  input logic            pwr_en_pull,
  input logic            fshut_pull,
  input logic            rst_out,
  input logic            seq_enable,
  input logic [6:0]      state_oh
);
  a_r12_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(state_oh) == 1);

  a_r6_lock_outputs: assert property (@(posedge clk) disable iff (rst)
    state_oh[B_LOCK] |-> (pwr_en_pull && fshut_pull && rst_out));

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    state_oh[B_LOCK] |=> state_oh[B_LOCK]);

  a_r3_delay_after_off: assert property (@(posedge clk) disable iff (rst)
    (state_oh[B_SHUT] && !(&chan_off)) |=> !state_oh[B_DELAY]);

  a_r4_line_held: assert property (@(posedge clk) disable iff (rst)
    (state_oh[B_SHUT] || state_oh[B_DELAY]) |-> pwr_en_pull);

  a_r7_unlimited: assert property (@(posedge clk) disable iff (rst)
    (retry_cfg[1] && !state_oh[B_LOCK]) |=> !state_oh[B_LOCK]);

  a_r10_seq_needs_en: assert property (@(posedge clk) disable iff (rst)
    seq_enable |-> $past(pwr_en_in));
endmodule

bind pwr_restart_ctrl pwr_restart_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst(rst), .pwr_en_in(pwr_en_in), .chan_off(chan_off),
  .retry_cfg(retry_cfg), .pwr_en_pull(pwr_en_pull), .fshut_pull(fshut_pull),
  .rst_out(rst_out), .seq_enable(seq_enable), .state_oh(state_oh)
);

// File: tb/pwr_restart_ctrl_bench.sv
module pwr_restart_ctrl_bench;
  localparam int NC  = 4;
  localparam int NS  = 2;
  localparam int CMD = 20;
  localparam int FLT = 50;
  localparam logic [6:0] S_IDLE = 7'b0000001, S_SEQ = 7'b0000010,
    S_MON = 7'b0000100, S_SHUT = 7'b0001000, S_DLY = 7'b0010000,
    S_VAL = 7'b0100000, S_LOCK = 7'b1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_en_in = 1'b0, fshut_in = 1'b0, fault_fs = 1'b0, fault_poff = 1'b0;
  logic seq_timeout = 1'b0, cmd_off = 1'b0, cmd_on = 1'b0;
  logic [NC-1:0] chan_off = '1;
  logic [NS-1:0] supply_ok = '0, valid_sel = '0;
  logic [1:0] retry_cfg = 2'b10;
  logic pwr_en_pull, fshut_pull, rst_out, seq_enable, poff_active;
  logic [6:0] state_oh;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [6:0] st;
    logic [4:0] outs;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  pwr_restart_ctrl #(.CLK_HZ(125_000_000), .N_CH(NC), .N_SUP(NS),
                     .CMD_DLY_CYC(CMD), .FLT_DLY_CYC(FLT)) u_pwr_restart_ctrl (
    .clk(clk), .rst(rst), .pwr_en_in(pwr_en_in), .fshut_in(fshut_in),
    .chan_off(chan_off), .fault_fs(fault_fs), .fault_poff(fault_poff),
    .seq_timeout(seq_timeout), .supply_ok(supply_ok), .valid_sel(valid_sel),
    .retry_cfg(retry_cfg), .cmd_off(cmd_off), .cmd_on(cmd_on),
    .pwr_en_pull(pwr_en_pull), .fshut_pull(fshut_pull), .rst_out(rst_out),
    .seq_enable(seq_enable), .poff_active(poff_active), .state_oh(state_oh)
  );

  // Monitor: pops one expected item after each edge and compares.
  always begin
    @(posedge clk);
    #2;
    if (sb.size() > 0) begin
      exp_t it;
      logic [4:0] act;
      it  = sb.pop_front();
      act = {pwr_en_pull, fshut_pull, rst_out, seq_enable, poff_active};
      n_chk++;
      if (state_oh !== it.st || act !== it.outs) begin
        n_err++;
        $display("FAIL %s: state=%b outs=%b expected state=%b outs=%b",
                 it.tag, state_oh, act, it.st, it.outs);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  // Driver side: predict the state after the coming edge.
  task automatic expect_st(logic [6:0] st, logic [4:0] outs, string tag);
    exp_t it;
    it.st = st; it.outs = outs; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic bring_up();
    pwr_en_in = 1'b1;
    chan_off  = '0;
    for (int i = 0; i < 400 && state_oh != S_MON; i++) step();
    if (state_oh != S_MON) begin
      n_chk++; n_err++;
      $display("FAIL R9 bring-up: state=%b expected %b", state_oh, S_MON);
    end
  endtask

  task automatic fault_cycle(bit lock, string tag);
    step(); fault_poff = 1'b1;
    expect_st(S_SHUT, 5'b10000, tag);
    step(); fault_poff = 1'b0; chan_off = '1;
    expect_st(lock ? S_LOCK : S_DLY, lock ? 5'b11100 : 5'b10000, tag);
    if (!lock) begin
      repeat (FLT) step();
      bring_up();
    end
  endtask

  task automatic do_reset();
    step(); rst = 1'b1; chan_off = '1;
    expect_st(S_IDLE, 5'b00000, "R1 reset state");
    step(); rst = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not end, expected completion");
    if (!finished) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (2) step();
    do_reset();

    // R9: wait for selected supplies
    valid_sel = 2'b11; supply_ok = 2'b01; pwr_en_in = 1'b1;
    expect_st(S_VAL, 5'b00000, "R9 enter wait-valid");
    step(); expect_st(S_VAL, 5'b00000, "R9 hold while supply invalid");
    step(); supply_ok = 2'b11;
    expect_st(S_SEQ, 5'b00010, "R9 seq allowed once valid");
    step(); expect_st(S_SEQ, 5'b00010, "R10 seq_enable only in SEQ_ON");
    step(); chan_off = '0;
    expect_st(S_MON, 5'b00000, "R10 to monitor when rails up");

    // R10: power-off command hold
    step(); cmd_off = 1'b1;
    expect_st(S_MON, 5'b00001, "R10 poff set");
    step(); cmd_off = 1'b0;
    expect_st(S_MON, 5'b00001, "R10 poff holds");
    step(); cmd_on = 1'b1;
    expect_st(S_MON, 5'b00000, "R10 poff cleared");
    step(); cmd_on = 1'b0;

    // R2/R3/R4: command restart by force-shutdown
    fshut_in = 1'b1;
    expect_st(S_SHUT, 5'b10000, "R2 force-shutdown command");
    step(); fshut_in = 1'b0; chan_off = 4'b0111;
    expect_st(S_SHUT, 5'b10000, "R3 wait for all rails off");
    step(); expect_st(S_SHUT, 5'b10000, "R3 still waiting");
    step(); chan_off = '1;
    expect_st(S_DLY, 5'b10000, "R4 command delay start");
    repeat (CMD - 1) step();
    expect_st(S_DLY, 5'b10000, "R4 last delay cycle");
    step(); expect_st(S_IDLE, 5'b00000, "R4 released after command delay");
    valid_sel = '0;
    bring_up();

    // R2: power-enable dropped by outside
    step(); pwr_en_in = 1'b0;
    expect_st(S_SHUT, 5'b10000, "R2 power-enable low");
    step(); pwr_en_in = 1'b1; chan_off = '1;
    expect_st(S_DLY, 5'b10000, "R4 delay after enable drop");
    repeat (CMD) step();
    bring_up();

    // R11: fault forcing shutdown drives force-shutdown line
    step(); fault_fs = 1'b1;
    expect_st(S_SHUT, 5'b11000, "R11 fshut pulled on fault");
    step(); fault_fs = 1'b0;
    expect_st(S_SHUT, 5'b11000, "R11 fshut held while rails up");
    step(); chan_off = '1;
    expect_st(S_DLY, 5'b10000, "R5 fault delay start");
    repeat (FLT - 1) step();
    expect_st(S_DLY, 5'b10000, "R5 last fault delay cycle");
    step(); expect_st(S_IDLE, 5'b00000, "R5 released after fault delay");

    // R2: sequencing timeout in SEQ_ON is a fault
    pwr_en_in = 1'b1; chan_off = 4'b1000;
    for (int i = 0; i < 20 && state_oh != S_SEQ; i++) step();
    step(); seq_timeout = 1'b1;
    expect_st(S_SHUT, 5'b10000, "R2 sequence timeout");
    step(); seq_timeout = 1'b0; chan_off = '1;
    expect_st(S_DLY, 5'b10000, "R2 timeout restart");
    repeat (FLT) step();
    bring_up();

    // R7: unlimited never locks out
    for (int k = 0; k < 5; k++) fault_cycle(1'b0, "R7 unlimited retries");

    // R7 / R6 / R8: one retry
    do_reset(); retry_cfg = 2'b00;
    bring_up();
    fault_cycle(1'b0, "R7 first fault restarts (limit one)");
    fault_cycle(1'b1, "R6 lockout after second fault");
    step(); pwr_en_in = 1'b0; fshut_in = 1'b1; cmd_on = 1'b1; chan_off = '0;
    expect_st(S_LOCK, 5'b11100, "R8 lockout ignores inputs");
    step(); pwr_en_in = 1'b1; fshut_in = 1'b0; cmd_on = 1'b0; chan_off = '1;
    expect_st(S_LOCK, 5'b11100, "R8 lockout persists");
    do_reset();

    // R7: three retries
    retry_cfg = 2'b01;
    bring_up();
    for (int k = 0; k < 3; k++) fault_cycle(1'b0, "R7 restart within limit three");
    fault_cycle(1'b1, "R7 lockout on fourth fault");
    do_reset();
    pwr_en_in = 1'b1;
    expect_st(S_VAL, 5'b00000, "R8 restart after power cycle");
    step(); step();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule